// File: doc/BRIEF.md
# Shared-Unit Reaction Velocity Pipeline

This block evaluates one fixed reaction-velocity expression, v = V·(S+Ka) / ((Km+Ac+S+Ka)·(Km+Ac)), on a fully pipelined datapath. Operands arrive on two narrow ports. One port carries only the two concentrations. The other carries only the three coefficients. Each port delivers one value per clock. Because the coefficient port needs three cycles per instance, the pipeline accepts a new instance every three cycles. That interval is the larger of the two argument counts.

The datapath holds only one adder, one multiplier and one divider. All three are pipelined fixed-latency Q16.16 signed operators, with latencies of 6, 8 and 17 cycles. The three additions share the adder and the two multiplications share the multiplier. Each operation owns a fixed slot of a free-running modulo-3 phase counter, and that counter drives the operand multiplexers. Delay lines hold intermediate values until their partner operand is ready. A single-cycle valid strobe marks each result, a fixed number of cycles after the instance started.

Top module: `rate_law_pipe`

## Requirements
- R1: While reset (active-low, synchronous) is held, and until an accepted start has travelled through the pipeline, `resultValid` is 0.
- R2: The rising edges after reset release are numbered from 0. A start strobe is accepted only on an edge whose number is a multiple of 3. A strobe on any other edge produces no result and does not disturb the instances already in flight.
- R3: Take an instance accepted at edge n. S and V are sampled at edge n, Ac and Km at edge n+1, and Ka at edge n+2. The concentration port at edge n+2, and the port values on edges that belong to no instance, do not affect any result.
- R4: `resultValid` is high for exactly one cycle, right after edge n+39, for an instance accepted at edge n. `resultOut` holds that instance's velocity in that same cycle.
- R5: Instances may start on consecutive phase-0 edges, every 3 cycles. Each result depends only on its own operands.
- R6: All values are 32-bit two's-complement Q16.16. Each sum wraps modulo 2^32.
- R7: A product is the full 64-bit signed product, arithmetic-shifted right by 16, keeping the low 32 bits.
- R8: For a nonzero divisor, the quotient is (dividend·2^16)/divisor, truncated toward zero. It is clamped to the range 0x80000000 to 0x7FFFFFFF.
- R9: For a zero divisor, the quotient is 0x7FFFFFFF when the dividend is non-negative, and 0x80000000 otherwise.
- R10: Two `resultValid` pulses are never less than 3 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startIn | input | 1 | Start strobe for an instance; honoured only on phase-0 edges |
| concIn | input | 32 | Concentration operand stream (S, then Ac) |
| coefIn | input | 32 | Coefficient operand stream (V, Km, then Ka) |
| resultOut | output | 32 | Velocity in Q16.16 |
| resultValid | output | 1 | One-cycle strobe qualifying `resultOut` |

## Verification
The assertions assume that reset is released synchronously. They also assume that an instance's operands sit on the ports at exactly the edges its start implies, since the shared units cannot tell one instance from another. The bench builds its stimulus from a per-edge plan. It places the operands of every accepted instance on their fixed edges and fills all other port cycles with random values. It then adds stray start strobes only on edges where the phase is not 0. That keeps the stimulus inside the assumed input discipline while still exercising the cases that must be ignored.

// File: rtl/rate_law_pkg.sv
package rate_law_pkg;
  // argument counts per instance on each input port
  localparam int NUM_CONC = 2;
  localparam int NUM_COEF = 3;
  localparam int PITCH    = (NUM_CONC > NUM_COEF) ? NUM_CONC : NUM_COEF;
  localparam int SLOT_W   = $clog2(PITCH);

  // fixed operator latencies
  localparam int ADD_LAT = 6;
  localparam int MUL_LAT = 8;
  localparam int DIV_LAT = 17;

  // issue cycles relative to the start cycle
  localparam int T_A2   = 1;                        // Km + Ac straight off the ports
  localparam int T_A1   = NUM_COEF - 1;             // S + Ka when Ka arrives
  localparam int A2_RDY = T_A2 + ADD_LAT;
  localparam int A1_RDY = T_A1 + ADD_LAT;
  localparam int T_A3   = ((A1_RDY + PITCH - 1) / PITCH) * PITCH;
  localparam int A3_RDY = T_A3 + ADD_LAT;
  localparam int T_M1   = A1_RDY;
  localparam int T_M2   = A3_RDY;
  localparam int M1_RDY = T_M1 + MUL_LAT;
  localparam int M2_RDY = T_M2 + MUL_LAT;
  localparam int T_DIV  = M2_RDY;
  localparam int LATENCY = T_DIV + DIV_LAT;

  // alignment delays
  localparam int S_DLY     = T_A1;
  localparam int V_DLY     = T_M1;
  localparam int A1_TO_A3  = T_A3 - A1_RDY;
  localparam int A2_TO_A3  = T_A3 - A2_RDY;
  localparam int A2_TO_M2  = T_M2 - A2_RDY;
  localparam int M1_TO_DIV = T_DIV - M1_RDY;

  // modulo slots owned by each shared operation
  localparam int SLOT_A1 = T_A1 % PITCH;
  localparam int SLOT_A3 = T_A3 % PITCH;
  localparam int SLOT_M2 = T_M2 % PITCH;

  typedef enum logic [1:0] {ADD_KM_AC, ADD_S_KA, ADD_SUMS} addSel_e;
  typedef enum logic       {MUL_V_A1, MUL_A3_A2}           mulSel_e;

  typedef struct packed {
    addSel_e addSel;
    mulSel_e mulSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/rl_delay.sv
module rl_delay #(
  parameter int W     = 32,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [DEPTH-1:0][W-1:0] stages;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stages <= '0;
    end else begin
      stages[0] <= din;
      for (int i = 1; i < DEPTH; i++) stages[i] <= stages[i-1];
    end
  end

  assign dout = stages[DEPTH-1];
endmodule

// File: rtl/rl_ctrl.sv
module rl_ctrl
  import rate_law_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  output logic [SLOT_W-1:0] slot,
  output ctrlStrobes_t      strobes,
  output logic              resultValid
);
  logic accept;
  logic validTail;

  always_ff @(posedge clk) begin
    if (!rstN) slot <= '0;
    else if (slot == SLOT_W'(PITCH - 1)) slot <= '0;
    else slot <= slot + SLOT_W'(1);
  end

  assign accept = startIn && (slot == '0);

  always_comb begin
    if (slot == SLOT_W'(SLOT_A3))      strobes.addSel = ADD_SUMS;
    else if (slot == SLOT_W'(SLOT_A1)) strobes.addSel = ADD_S_KA;
    else                               strobes.addSel = ADD_KM_AC;
    strobes.mulSel = (slot == SLOT_W'(SLOT_M2)) ? MUL_A3_A2 : MUL_V_A1;
  end

  rl_delay #(.W(1), .DEPTH(LATENCY)) validLine (
    .clk(clk), .rstN(rstN), .din(accept), .dout(validTail)
  );

  assign resultValid = validTail;
endmodule

// File: rtl/rl_datapath.sv
module rl_datapath
  import rate_law_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] concIn,
  input  logic [DATA_W-1:0] coefIn,
  output logic [DATA_W-1:0] resultOut
);
  localparam int PW = 2 * DATA_W;

  logic [DATA_W-1:0] sAligned, vAligned;
  logic [DATA_W-1:0] addA, addB, addSum, addOut;
  logic [DATA_W-1:0] a1Held, a2Near, a2Far;
  logic [DATA_W-1:0] mulA, mulB, mulRes, mulOut, m1Held;
  logic [PW-1:0]     prodFull;
  logic [PW-1:0]     numFull, denFull, quotFull;
  logic [DATA_W-1:0] divRes;

  // operand alignment for values read straight from the ports
  rl_delay #(.W(DATA_W), .DEPTH(S_DLY)) sLine (.clk(clk), .rstN(rstN), .din(concIn), .dout(sAligned));
  rl_delay #(.W(DATA_W), .DEPTH(V_DLY)) vLine (.clk(clk), .rstN(rstN), .din(coefIn), .dout(vAligned));

  // shared adder
  always_comb begin
    unique case (strobes.addSel)
      ADD_S_KA: begin addA = sAligned; addB = coefIn; end
      ADD_SUMS: begin addA = a1Held;   addB = a2Near; end
      default:  begin addA = concIn;   addB = coefIn; end
    endcase
  end
  assign addSum = addA + addB;
  rl_delay #(.W(DATA_W), .DEPTH(ADD_LAT)) addPipe (.clk(clk), .rstN(rstN), .din(addSum), .dout(addOut));

  // intermediate sums held for their later consumers
  rl_delay #(.W(DATA_W), .DEPTH(A1_TO_A3)) a1Line (.clk(clk), .rstN(rstN), .din(addOut), .dout(a1Held));
  rl_delay #(.W(DATA_W), .DEPTH(A2_TO_A3)) a2NearLine (.clk(clk), .rstN(rstN), .din(addOut), .dout(a2Near));
  rl_delay #(.W(DATA_W), .DEPTH(A2_TO_M2 - A2_TO_A3)) a2FarLine (.clk(clk), .rstN(rstN), .din(a2Near), .dout(a2Far));

  // shared multiplier
  always_comb begin
    unique case (strobes.mulSel)
      MUL_A3_A2: begin mulA = addOut;   mulB = a2Far;  end
      default:   begin mulA = vAligned; mulB = addOut; end
    endcase
  end
  assign prodFull = $signed({{DATA_W{mulA[DATA_W-1]}}, mulA}) * $signed({{DATA_W{mulB[DATA_W-1]}}, mulB});
  assign mulRes   = DATA_W'(prodFull >> FRAC_W);
  rl_delay #(.W(DATA_W), .DEPTH(MUL_LAT)) mulPipe (.clk(clk), .rstN(rstN), .din(mulRes), .dout(mulOut));

  rl_delay #(.W(DATA_W), .DEPTH(M1_TO_DIV)) m1Line (.clk(clk), .rstN(rstN), .din(mulOut), .dout(m1Held));

  // divider: numerator m1, denominator m2, saturating
  assign numFull  = {{(DATA_W - FRAC_W){m1Held[DATA_W-1]}}, m1Held, {FRAC_W{1'b0}}};
  assign denFull  = {{DATA_W{mulOut[DATA_W-1]}}, mulOut};
  assign quotFull = (mulOut == '0) ? '0 : PW'($signed(numFull) / $signed(denFull));

  always_comb begin
    if (mulOut == '0)
      divRes = m1Held[DATA_W-1] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    else if (quotFull[PW-1:DATA_W-1] != {(DATA_W+1){quotFull[PW-1]}})
      divRes = quotFull[PW-1] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    else
      divRes = quotFull[DATA_W-1:0];
  end
  rl_delay #(.W(DATA_W), .DEPTH(DIV_LAT)) divPipe (.clk(clk), .rstN(rstN), .din(divRes), .dout(resultOut));
endmodule

// File: rtl/rate_law_pipe.sv
module rate_law_pipe
  import rate_law_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [DATA_W-1:0] concIn,
  input  logic [DATA_W-1:0] coefIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              resultValid
);
  logic [SLOT_W-1:0] slot;
  ctrlStrobes_t      strobes;

  rl_ctrl ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .slot(slot), .strobes(strobes), .resultValid(resultValid)
  );

  rl_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .concIn(concIn), .coefIn(coefIn), .resultOut(resultOut)
  );
endmodule

// File: rtl/rate_law_pipe_chk.sv
module rate_law_pipe_chk
  import rate_law_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic              resultValid,
  input logic [SLOT_W-1:0] slot
);
  logic [SLOT_W-1:0]  phase;
  logic [LATENCY-1:0] seenStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= '0;
      seenStart <= '0;
    end else begin
      phase     <= (phase == SLOT_W'(PITCH - 1)) ? '0 : phase + SLOT_W'(1);
      seenStart <= {seenStart[LATENCY-2:0], startIn && (phase == '0)};
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !resultValid);

  // R2
  slot_phase_chk: assert property (@(posedge clk) disable iff (!rstN) slot == phase);

  // R4
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN) resultValid == seenStart[LATENCY-1]);

  // R10
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rstN) resultValid |=> !resultValid);

  // R10
  valid_gap2_chk: assert property (@(posedge clk) disable iff (!rstN) resultValid |=> ##1 !resultValid);
endmodule

bind rate_law_pipe rate_law_pipe_chk chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .resultValid(resultValid), .slot(slot)
);

// File: tb/tb_rate_law_pipe.sv
`timescale 1ns/1ps
module tb_rate_law_pipe;
  localparam int ARR    = 1100;
  localparam int N_INST = 330;
  localparam int LAT_E  = 39;   // edges from accepting edge to result edge

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] concIn = '0;
  logic [31:0] coefIn = '0;
  logic [31:0] resultOut;
  logic        resultValid;

  int checks = 0;
  int errors = 0;
  int edgeNo = 0;
  int lastValid = -100;
  bit running = 0;
  bit done = 0;

  bit          planStart [0:ARR-1];
  logic [31:0] concPlan  [0:ARR-1];
  logic [31:0] coefPlan  [0:ARR-1];
  bit          expVal    [0:ARR-1];
  logic [31:0] expRes    [0:ARR-1];
  string       expTag    [0:ARR-1];
  string       validTag  [0:ARR-1];

  rate_law_pipe dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .concIn(concIn), .coefIn(coefIn),
    .resultOut(resultOut), .resultValid(resultValid)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rstN) edgeNo <= edgeNo + 1;

  function automatic logic [31:0] fxMul(logic [31:0] a, logic [31:0] b);
    longint pa, pb, p;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    p  = pa * pb;
    return p[47:16];
  endfunction

  function automatic logic [31:0] fxDiv(logic [31:0] a, logic [31:0] b);
    longint n, d, q;
    if (b == 32'd0) return a[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    n = longint'($signed(a)) * 65536;
    d = longint'($signed(b));
    q = n / d;
    if (q > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (q < -64'sd2147483648) return 32'h8000_0000;
    return q[31:0];
  endfunction

  function automatic logic [31:0] refVel(logic [31:0] s, logic [31:0] ac, logic [31:0] v,
                                         logic [31:0] km, logic [31:0] ka);
    logic [31:0] a1, a2, a3;
    a1 = s + ka;
    a2 = km + ac;
    a3 = a1 + a2;
    return fxDiv(fxMul(v, a1), fxMul(a3, a2));
  endfunction

  function automatic logic [31:0] rndVal();
    if ($urandom % 2 == 0) return 32'($urandom % 32'h0010_0000) - 32'h0008_0000;
    return $urandom;
  endfunction

  task automatic planInst(int n, logic [31:0] s, logic [31:0] ac, logic [31:0] v,
                          logic [31:0] km, logic [31:0] ka, string tag);
    planStart[n]  = 1;
    concPlan[n]   = s;  concPlan[n+1] = ac;
    coefPlan[n]   = v;  coefPlan[n+1] = km;  coefPlan[n+2] = ka;
    expVal[n+LAT_E] = 1;
    expRes[n+LAT_E] = refVel(s, ac, v, km, ka);
    expTag[n+LAT_E] = tag;
  endtask

  // per-edge checks at the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      checks++;
      if (resultValid !== 1'b0) begin
        errors++;
        $display("FAIL R1 valid during reset actual=%b expected=0", resultValid);
      end
    end else if (running && edgeNo > 0) begin
      automatic int e = edgeNo - 1;
      automatic string vt = (e < LAT_E) ? "R1" : (expVal[e] ? "R4" : validTag[e]);
      checks++;
      if (resultValid !== expVal[e]) begin
        errors++;
        $display("FAIL %s valid at edge %0d actual=%b expected=%b", vt, e, resultValid, expVal[e]);
      end
      if (resultValid === 1'b1) begin
        // R10 spacing of result strobes
        checks++;
        if (e - lastValid < 3) begin
          errors++;
          $display("FAIL R10 pulse gap at edge %0d actual=%0d expected>=3", e, e - lastValid);
        end
        lastValid = e;
      end
      if (expVal[e] && resultValid === 1'b1) begin
        checks++;
        if (resultOut !== expRes[e]) begin
          errors++;
          $display("FAIL %s result at edge %0d actual=%h expected=%h", expTag[e], e, resultOut, expRes[e]);
        end
      end
    end
  end

  initial begin
    void'($urandom(32'd4417));
    for (int i = 0; i < ARR; i++) begin
      planStart[i] = 0;
      concPlan[i]  = $urandom;   // R3: idle port cycles carry noise
      coefPlan[i]  = $urandom;
      expVal[i]    = 0;
      expRes[i]    = '0;
      expTag[i]    = "R4";
      validTag[i]  = "R4";
    end
    // directed instances
    planInst(0, 32'h0001_0000, 32'h0000_8000, 32'h0002_0000, 32'h0000_8000, 32'h0001_0000, "R3");
    planInst(3, 32'h0001_0000, 32'hFFFE_8000, 32'h0001_0000, 32'h0001_8000, 32'h0000_0000, "R9");
    planInst(6, 32'h0001_0000, 32'hFFFE_8000, 32'hFFFF_0000, 32'h0001_8000, 32'h0000_0000, "R9");
    planInst(9, 32'h0064_0000, 32'h0000_0000, 32'h0064_0000, 32'h0000_0001, 32'h0000_0000, "R8");
    planInst(12, 32'h7FFF_0000, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000, 32'h0002_0000, "R6");
    // random instances: a back-to-back run, then sparse starts
    for (int k = 5; k < N_INST; k++) begin
      automatic int n = 3 * k;
      automatic string tg = (k % 3 == 0) ? "R5" : ((k % 3 == 1) ? "R7" : "R3");
      if (k < 25 || ($urandom % 4) != 0)
        planInst(n, rndVal(), rndVal(), rndVal(), rndVal(), rndVal(), tg);
      // R2: stray strobes off phase 0
      for (int off = 1; off < 3; off++) begin
        if (($urandom % 4) == 0) begin
          planStart[n+off] = 1;
          validTag[n+off+LAT_E] = "R2";
        end
      end
    end

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    running = 1;
    for (int n = 0; n < 3 * N_INST + 50; n++) begin
      startIn = planStart[n];
      concIn  = concPlan[n];
      coefIn  = coefPlan[n];
      @(negedge clk);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule